// File: doc/BRIEF.md
# I2C Quad Wiper Register Controller

This block is the digital front end of a four-channel digitally controlled resistor. It is an I2C slave that holds four 8-bit wiper position registers, a per-channel shutdown flag and two general-purpose logic output bits. The analog network downstream reads the wiper codes and the shutdown flags directly from the outputs.

A write frame carries the slave address, then one instruction byte, then any number of data bytes. The instruction byte selects a channel and loads the logic outputs, the shutdown bit and an optional return to midscale. Every data byte that follows it overwrites the wiper of the selected channel until the frame ends. A read frame has no pointer byte. It returns the wiper of the channel that the most recent instruction selected, once for each byte the master acknowledges. An external active-low pin forces all channels into shutdown without changing any stored register.

The SCL and SDA inputs are sampled by the system clock through two-flop synchronisers with edge detection. For this reason the system clock must run several times faster than SCL.

Top module: `quad_wiper_i2c`

## Requirements
- R1: After reset every wiper holds 0x80, both logic outputs are 0, every channel shutdown flag is 0 and SDA is released (`sda_oe` = 0).
- R2: The slave acknowledges only the address byte {0101 1, strap[1], strap[0], R/W}, with R/W in bit 0. After any other address it does not acknowledge and ignores the rest of the frame.
- R3: In a write frame, the byte after the address is the instruction. Bits 2:1 of the instruction select channel 0..3. The next data byte is written to that channel's wiper, and every byte of the frame is acknowledged.
- R4: Further data bytes in the same write frame each overwrite the selected wiper. The other channels do not change.
- R5: With R/W = 1 the slave sends the selected channel's wiper, MSB first, straight after the address acknowledge. It repeats this for each byte the master acknowledges. On a master NACK it releases SDA and waits for the next start. A write frame that ends after the instruction byte is enough to select the channel.
- R6: Instruction bit 4 loads `gp_out[0]` and bit 3 loads `gp_out[1]`. A frame made of address plus instruction changes no wiper, whether it ends with a stop or is cut short by a repeated start.
- R7: Instruction bit 6 set returns the selected channel's wiper to 0x80.
- R8: Instruction bit 5 is written into the shutdown flag of the selected channel only. A value of 1 sets the flag and 0 clears it.
- R9: While `shdn_n` is low, all four `chan_shdn` outputs are 1. Wiper registers keep their values and can still be written.
- R10: `sda_oe` changes only while SCL is low.
- R11: A repeated start ends the data stream. The first byte after the next address is decoded as an instruction, not as data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 2 | Address strap inputs, low two address bits |
| shdn_n | input | 1 | External active-low shutdown |
| wiper_value | output | 32 | Four wiper codes, channel n in bits 8n+7:8n |
| chan_shdn | output | 4 | Per-channel shutdown, flag OR pin |
| gp_out | output | 2 | General-purpose logic outputs |

## Verification
The write path is tested in four ways: a single data byte to each channel in turn, a stream of data bytes into one channel, instruction-only frames, and a frame cut short by a repeated start. Together these show whether the target channel is latched from the instruction or from the data position. They also show whether streaming stops at a frame boundary. Readback is tested after a selection made by an instruction-only frame, with two acknowledged bytes before a NACK. This shows that the value is taken again from the selected channel each time and that SDA is released afterwards. Separate sequences use a foreign address, toggle shutdown flags across channels and hold the shutdown pin low. These show that a flag affects only its own channel and that the pin masks the registers without altering them.

// File: rtl/wiper_ctl_pkg.sv
// Shared types and instruction-byte field positions for the quad wiper controller.
package wiper_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_state_t;

    typedef enum logic [1:0] {
        BYTE_ADDR,
        BYTE_INSTR,
        BYTE_DATA
    } byte_kind_t;

    localparam int INS_MID_BIT = 6;
    localparam int INS_SD_BIT  = 5;
    localparam int INS_O1_BIT  = 4;
    localparam int INS_O2_BIT  = 3;
    localparam int INS_CH_LSB  = 1;
endpackage

// File: rtl/line_sync.sv
// Synchroniser for one bus line, with edge detection.
// Assumes the line idles high, so every stage resets to 1.
// The rise and fall strobes last one clock and are aligned with the level output.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the stages and keep the previous level for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/i2c_frame_engine.sv
// I2C slave framing for one device address.
// Receives the address, instruction and data bytes and drives the acknowledges.
// In read mode it sends rd_data MSB first.
// It reports a received instruction or data byte with a one-cycle strobe on rx_byte.
// Assumes synchronised SCL/SDA levels and edges from line_sync.
module i2c_frame_engine
    import wiper_ctl_pkg::*;
#(
    parameter int          BYTE_W     = 8,
    parameter int          PREFIX_W   = 5,
    parameter int          STRAP_W    = 2,
    parameter logic [4:0]  DEV_PREFIX = 5'b01011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic              sda_oe,
    output logic              instr_evt,
    output logic              data_evt,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    bus_state_t        state_q;
    byte_kind_t        kind_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] txreg_q;
    logic              rd_mode_q;
    logic              start_det;
    logic              stop_det;
    logic              addr_hit;

    // Start/stop: SDA edge while SCL is held high.
    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;
    assign addr_hit  = (shreg_q[BYTE_W-1:1] == {DEV_PREFIX[PREFIX_W-1:0], strap});

    // Frame sequencing: bit capture, acknowledge, transmit and master-ack phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            kind_q    <= BYTE_ADDR;
            cnt_q     <= '0;
            shreg_q   <= '0;
            txreg_q   <= '0;
            rd_mode_q <= 1'b0;
            sda_oe    <= 1'b0;
            instr_evt <= 1'b0;
            data_evt  <= 1'b0;
            rx_byte   <= '0;
        end else begin
            instr_evt <= 1'b0;
            data_evt  <= 1'b0;
            if (start_det) begin
                state_q <= ST_RX;
                kind_q  <= BYTE_ADDR;
                cnt_q   <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_RX: begin
                        if (scl_rise && cnt_q != CNT_W'(BYTE_W)) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                            cnt_q <= '0;
                            unique case (kind_q)
                                BYTE_ADDR: begin
                                    if (addr_hit) begin
                                        rd_mode_q <= shreg_q[0];
                                        kind_q    <= BYTE_INSTR;
                                        sda_oe    <= 1'b1;
                                        state_q   <= ST_ACK;
                                    end else begin
                                        state_q <= ST_IDLE;
                                    end
                                end
                                BYTE_INSTR: begin
                                    instr_evt <= 1'b1;
                                    rx_byte   <= shreg_q;
                                    kind_q    <= BYTE_DATA;
                                    sda_oe    <= 1'b1;
                                    state_q   <= ST_ACK;
                                end
                                default: begin
                                    data_evt <= 1'b1;
                                    rx_byte  <= shreg_q;
                                    sda_oe   <= 1'b1;
                                    state_q  <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rd_mode_q) begin
                                txreg_q <= rd_data;
                                sda_oe  <= ~rd_data[BYTE_W-1];
                                state_q <= ST_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                                sda_oe  <= 1'b0;
                                state_q <= ST_RACK;
                            end else begin
                                cnt_q   <= cnt_q + 1'b1;
                                txreg_q <= {txreg_q[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~txreg_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && sda_lvl) begin
                            state_q <= ST_IDLE;
                        end else if (scl_fall) begin
                            cnt_q   <= '0;
                            txreg_q <= rd_data;
                            sda_oe  <= ~rd_data[BYTE_W-1];
                            state_q <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // The slave only starts pulling SDA low while SCL is low.
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // A master NACK on a read byte returns the engine to idle with SDA released.
    assert_nack_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RACK && $past(scl_rise) && $past(sda_lvl)
         && !$past(start_det) && !$past(stop_det))
        |-> (state_q == ST_IDLE && !sda_oe));
endmodule

// File: rtl/wiper_regfile.sv
// Wiper, shutdown-flag and logic-output storage for the controller.
// An instruction strobe latches the channel selection and the flags.
// A data strobe writes the selected wiper.
// Assumes NUM_CH is a power of two so that the select field covers it exactly.
module wiper_regfile
    import wiper_ctl_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int WIPER_W = 8,
    parameter int GP_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      instr_evt,
    input  logic                      data_evt,
    input  logic [WIPER_W-1:0]        rx_byte,
    output logic [NUM_CH*WIPER_W-1:0] wiper_flat,
    output logic [NUM_CH-1:0]         sd_flags,
    output logic [GP_W-1:0]           gp_q,
    output logic [WIPER_W-1:0]        rd_data
);
    localparam int                 CH_W = $clog2(NUM_CH);
    localparam logic [WIPER_W-1:0] MID  = WIPER_W'(1) << (WIPER_W - 1);

    logic [WIPER_W-1:0] wiper_q [NUM_CH];
    logic [CH_W-1:0]    sel_q;
    logic [CH_W-1:0]    ch_new;

    assign ch_new  = rx_byte[INS_CH_LSB +: CH_W];
    assign rd_data = wiper_q[sel_q];

    // Apply an instruction (select, flags, midscale) or a data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) wiper_q[i] <= MID;
            sd_flags <= '0;
            gp_q     <= '0;
            sel_q    <= '0;
        end else if (instr_evt) begin
            sel_q            <= ch_new;
            gp_q             <= {rx_byte[INS_O2_BIT], rx_byte[INS_O1_BIT]};
            sd_flags[ch_new] <= rx_byte[INS_SD_BIT];
            if (rx_byte[INS_MID_BIT]) wiper_q[ch_new] <= MID;
        end else if (data_evt) begin
            wiper_q[sel_q] <= rx_byte;
        end
    end

    // Flatten the wiper array for the top-level port.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
        assign wiper_flat[g*WIPER_W +: WIPER_W] = wiper_q[g];
    end

    // Wipers move only after an instruction or data strobe.
    assert_wiper_by_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_flat) |-> $past(instr_evt || data_evt));

    // Logic outputs move only after an instruction strobe.
    assert_gp_by_instr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gp_q) |-> $past(instr_evt));

    // One instruction touches at most one channel's shutdown flag.
    assert_sd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sd_flags ^ $past(sd_flags)) <= 1);
endmodule

// File: rtl/quad_wiper_i2c.sv
// Top of the I2C quad wiper controller.
// Synchronises the bus lines, runs the slave frame engine and holds the registers.
// The external shutdown pin is ORed into every channel flag.
// Assumes clk is at least about 8x faster than SCL.
module quad_wiper_i2c #(
    parameter int NUM_CH      = 4,
    parameter int WIPER_W     = 8,
    parameter int STRAP_W     = 2,
    parameter int GP_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    output logic                      sda_oe,
    input  logic [STRAP_W-1:0]        strap,
    input  logic                      shdn_n,
    output logic [NUM_CH*WIPER_W-1:0] wiper_value,
    output logic [NUM_CH-1:0]         chan_shdn,
    output logic [GP_W-1:0]           gp_out
);
    logic               scl_lvl, scl_rise, scl_fall;
    logic               sda_lvl, sda_rise, sda_fall;
    logic               instr_evt, data_evt;
    logic [WIPER_W-1:0] rx_byte, rd_data;
    logic [NUM_CH-1:0]  sd_flags;

    line_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_in),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    line_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_in),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    i2c_frame_engine #(.BYTE_W(WIPER_W), .STRAP_W(STRAP_W)) i_engine (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .strap(strap), .rd_data(rd_data), .sda_oe(sda_oe),
        .instr_evt(instr_evt), .data_evt(data_evt), .rx_byte(rx_byte)
    );

    wiper_regfile #(.NUM_CH(NUM_CH), .WIPER_W(WIPER_W), .GP_W(GP_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .instr_evt(instr_evt), .data_evt(data_evt), .rx_byte(rx_byte),
        .wiper_flat(wiper_value), .sd_flags(sd_flags),
        .gp_q(gp_out), .rd_data(rd_data)
    );

    // Per-channel shutdown: the stored flag or the external pin (R9).
    assign chan_shdn = sd_flags | {NUM_CH{~shdn_n}};
endmodule

// File: tb/test_quad_wiper_i2c.sv
// Directed bench: an I2C master model drives the bus and a simple model tracks the expected registers.
module test_quad_wiper_i2c;
    localparam time CLK_P = 10ns;
    localparam time QTR   = CLK_P * 10;
    localparam logic [7:0] AW = 8'h5C;  // address 0101110, write
    localparam logic [7:0] AR = 8'h5D;  // same address, read

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_in = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [1:0]  strap = 2'b10;
    logic        shdn_n = 1'b1;
    logic [31:0] wiper_value;
    logic [3:0]  chan_shdn;
    logic [1:0]  gp_out;
    wire         sda_line = sda_m & ~sda_oe;

    int n_checks = 0;
    int n_err = 0;
    int oe_hi_changes = 0;
    bit done = 0;

    logic [7:0] exp_w [4];
    logic [3:0] exp_sd = '0;
    logic [1:0] exp_gp = '0;

    quad_wiper_i2c i_quad_wiper_i2c (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_line),
        .sda_oe(sda_oe), .strap(strap), .shdn_n(shdn_n),
        .wiper_value(wiper_value), .chan_shdn(chan_shdn), .gp_out(gp_out)
    );

    always #(CLK_P/2) clk = ~clk;

    // R10 monitor: any change of the slave drive while SCL is high.
    always @(sda_oe) if (rst_n && scl_in) oe_hi_changes++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_vec();
        return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
    endfunction

    // Model of an accepted instruction byte.
    function automatic void model_ins(input logic [7:0] ins);
        exp_gp = {ins[3], ins[4]};
        exp_sd[ins[2:1]] = ins[5];
        if (ins[6]) exp_w[ins[2:1]] = 8'h80;
    endfunction

    task automatic i2c_start();
        sda_m = 1'b1; #QTR; scl_in = 1'b1; #QTR; sda_m = 1'b0; #QTR; scl_in = 1'b0; #QTR;
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; #QTR; scl_in = 1'b1; #QTR; sda_m = 1'b1; #(QTR*2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; #QTR; scl_in = 1'b1; #(QTR*2); scl_in = 1'b0; #QTR;
        end
        sda_m = 1'b1; #QTR; scl_in = 1'b1; #QTR;
        acked = ~sda_line;
        #QTR; scl_in = 1'b0; #QTR;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #QTR; scl_in = 1'b1; #QTR; d[i] = sda_line; #QTR; scl_in = 1'b0; #QTR;
        end
        sda_m = ~give_ack; #QTR; scl_in = 1'b1; #(QTR*2); scl_in = 1'b0; #QTR;
        sda_m = 1'b1;
    endtask

    task automatic t_reset_state();
        check("R1 wipers", wiper_value, 32'h80808080);
        check("R1 gp_out", gp_out, 0);
        check("R1 chan_shdn", chan_shdn, 0);
        check("R1 sda_oe", sda_oe, 0);
    endtask

    task automatic t_write_channels();
        logic a;
        for (int ch = 0; ch < 4; ch++) begin
            logic [7:0] v = 8'h11 * (ch + 1) + 8'(ch);
            i2c_start();
            send_byte(AW, a); check("R2 address ack", a, 1);
            send_byte(8'(ch << 1), a); check("R3 instr ack", a, 1);
            model_ins(8'(ch << 1));
            send_byte(v, a); check("R3 data ack", a, 1);
            exp_w[ch] = v;
            i2c_stop();
            check("R3 wiper written", wiper_value, exp_vec());
        end
    endtask

    task automatic t_stream();
        logic a;
        i2c_start();
        send_byte(AW, a);
        send_byte(8'h04, a); model_ins(8'h04);
        for (int k = 1; k <= 3; k++) begin
            send_byte(8'(k * 16), a);
            exp_w[2] = 8'(k * 16);
            check("R4 stream ack", a, 1);
            check("R4 stream value", wiper_value, exp_vec());
        end
        i2c_stop();
    endtask

    task automatic t_readback();
        logic a;
        logic [7:0] d;
        i2c_start(); send_byte(AW, a); send_byte(8'h02, a); model_ins(8'h02); i2c_stop();
        i2c_start();
        send_byte(AR, a); check("R5 read address ack", a, 1);
        recv_byte(1'b1, d); check("R5 read byte 1", d, exp_w[1]);
        recv_byte(1'b1, d); check("R5 read byte 2", d, exp_w[1]);
        recv_byte(1'b0, d); check("R5 read byte 3", d, exp_w[1]);
        check("R5 released after nack", sda_oe, 0);
        i2c_stop();
        check("R5 read leaves wipers", wiper_value, exp_vec());
    endtask

    task automatic t_gp_outputs();
        logic a;
        i2c_start(); send_byte(AW, a); send_byte(8'h10, a); model_ins(8'h10); i2c_stop();
        check("R6 gp O1", gp_out, 2'b01);
        check("R6 wipers kept", wiper_value, exp_vec());
        i2c_start(); send_byte(AW, a); send_byte(8'h08, a); model_ins(8'h08);
        check("R6 gp O2 before restart", gp_out, 2'b10);
        i2c_start(); send_byte(AW, a); send_byte(8'h18, a); model_ins(8'h18); i2c_stop();
        check("R6 gp both", gp_out, 2'b11);
        check("R6 wipers kept after restart", wiper_value, exp_vec());
    endtask

    task automatic t_midscale();
        logic a;
        i2c_start(); send_byte(AW, a); send_byte(8'h40, a); model_ins(8'h40); i2c_stop();
        check("R7 midscale ch0", wiper_value, exp_vec());
        check("R7 midscale value", wiper_value[7:0], 8'h80);
    endtask

    task automatic t_sd_bit();
        logic a;
        logic [7:0] seq [4] = '{8'h24, 8'h22, 8'h04, 8'h02};
        logic [3:0] want [4] = '{4'b0100, 4'b0110, 4'b0010, 4'b0000};
        for (int k = 0; k < 4; k++) begin
            i2c_start(); send_byte(AW, a); send_byte(seq[k], a); model_ins(seq[k]); i2c_stop();
            check("R8 shutdown flags", chan_shdn, want[k]);
            check("R8 model agrees", exp_sd, want[k]);
        end
        check("R8 wipers kept", wiper_value, exp_vec());
    endtask

    task automatic t_shdn_pin();
        logic a;
        shdn_n = 1'b0; #QTR;
        check("R9 pin forces all", chan_shdn, 4'hF);
        check("R9 wipers kept", wiper_value, exp_vec());
        i2c_start(); send_byte(AW, a); send_byte(8'h06, a); model_ins(8'h06);
        send_byte(8'h5A, a); exp_w[3] = 8'h5A; i2c_stop();
        check("R9 write while shut", wiper_value, exp_vec());
        shdn_n = 1'b1; #QTR;
        check("R9 pin released", chan_shdn, exp_sd);
    endtask

    task automatic t_bad_address();
        logic a;
        i2c_start();
        send_byte(8'h58, a); check("R2 foreign address nack", a, 0);
        send_byte(8'h5E, a); check("R2 following byte nack", a, 0);
        send_byte(8'hEE, a);
        i2c_stop();
        check("R2 wipers untouched", wiper_value, exp_vec());
        check("R2 gp untouched", gp_out, exp_gp);
        check("R2 flags untouched", chan_shdn, exp_sd);
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] d;
        i2c_start(); send_byte(AW, a); send_byte(8'h00, a); model_ins(8'h00);
        send_byte(8'h33, a); exp_w[0] = 8'h33;
        i2c_start(); send_byte(AW, a); send_byte(8'h04, a); model_ins(8'h04); i2c_stop();
        check("R11 byte after restart is instruction", wiper_value, exp_vec());
        i2c_start(); send_byte(AR, a); recv_byte(1'b0, d); i2c_stop();
        check("R11 restart selected ch2", d, exp_w[2]);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_w[i] = 8'h80;
        #2;
        #(CLK_P * 5);
        rst_n = 1'b1;
        #(CLK_P * 5);
        t_reset_state();
        t_write_channels();
        t_stream();
        t_readback();
        t_gp_outputs();
        t_midscale();
        t_sd_bit();
        t_shdn_pin();
        t_bad_address();
        t_restart();
        check("R10 sda_oe changes with SCL high", oe_hi_changes, 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule